// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This unit owns the fetch address of a 32-bit load-store processor. It offers the current program counter on `fetch_addr` and, each clock, chooses the next one. The choice is driven by a decoded control class from the instruction decoder. That class selects one of these:

- plain sequential stepping;
- an equal or not-equal compare of two register operands, steering a PC-relative branch;
- an absolute jump built from a 26-bit word target;
- a jump that also produces a return address;
- an indirect jump through a register value.

All inputs describe the instruction held at the current `fetch_addr` and are sampled at the rising edge that retires it. The link value and its write strobe are combinational from the current PC and class, so a register file can capture them at the same edge the PC moves. A stall input freezes the PC and suppresses the link write. A synchronous reset returns the PC to address zero.

Internally a comparator decides branch conditions, a target generator forms the sequential, branch and jump addresses, and a selector picks one of them by class. Class codes are one of:

- SEQ = 0
- BEQ = 1
- BNE = 2
- JMP = 3
- JAL = 4
- JRG = 5

Codes 6 and 7 behave as SEQ. The update rule has two cases:

- With reset or stall active, the register keeps the reset value or its held value.
- Otherwise the register loads the selected address.

Top module: `pcu_top`

## Requirements
- R1: While `rst` is high at a rising edge, `fetch_addr` becomes 0 after that edge, and `link_we` is low during reset.
- R2: With class 0 (SEQ), or with the unused codes 6 or 7, the next `fetch_addr` is the current one plus 4.
- R3: With class 1 (BEQ), when `opnd_a` equals `opnd_b` the next address is PC + 4 + (sign-extended `br_off` × 4); otherwise it is PC + 4.
- R4: With class 2 (BNE), when `opnd_a` differs from `opnd_b` the branch target above is taken; otherwise the next address is PC + 4.
- R5: `br_off` is a signed 16-bit word count, so an offset of 0xFFFF taken lands on the current PC itself (a backward branch).
- R6: With class 3 (JMP), the next address is bits 31..28 of PC + 4, then `jmp_field` (26 bits), then two zero bits; a field of 2500 from a PC below 0x1000_0000 gives 10000.
- R7: With class 4 (JAL), the jump of R6 is taken, and in that cycle `link_we` is high with `link_val` = PC + 4 and `link_idx` = 31.
- R8: With class 5 (JRG), the next address equals `jr_addr`.
- R9: While `stall` is high (and `rst` low), `fetch_addr` keeps its value across the edge and `link_we` is low.
- R10: `link_we` is high only for class 4 with `stall` and `rst` low, so it is high for exactly one cycle per executed JAL and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold PC and block link write |
| ctl_class | input | 3 | Decoded control class code |
| br_off | input | 16 | Signed branch offset in words |
| jmp_field | input | 26 | Absolute jump word target |
| opnd_a | input | 32 | First compare operand |
| opnd_b | input | 32 | Second compare operand |
| jr_addr | input | 32 | Register value for indirect jump |
| fetch_addr | output | 32 | Current program counter |
| link_val | output | 32 | Return address (PC + 4) |
| link_idx | output | 5 | Return register index, always 31 |
| link_we | output | 1 | Return register write strobe |

## Verification
Directed vectors first do these:

- Run straight-line code, which separates a stepping PC from a stuck one.
- Give each branch class equal and unequal operands, which separates a taken branch from a fall-through. Operands that differ in one high byte only catch a comparator that looks at part of the word.
- Branch with positive, zero and all-ones offsets, which exposes a missing sign extension or word scaling.
- Jump from PCs with different upper nibbles, with the 2500 field, which shows whether the upper bits are kept and the word shift is applied.

Stalls are placed before, during and after JAL to show that the strobe and the PC both freeze. A long random mix of classes and operands, with reset dropped in mid-run, is then checked every clock against a behavioural model.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [2:0] {
        CLS_SEQ = 3'd0,
        CLS_BEQ = 3'd1,
        CLS_BNE = 3'd2,
        CLS_JMP = 3'd3,
        CLS_JAL = 3'd4,
        CLS_JRG = 3'd5
    } pcu_class_e;

    typedef enum logic [1:0] {
        SRC_SEQ = 2'd0,
        SRC_BR  = 2'd1,
        SRC_JMP = 2'd2,
        SRC_REG = 2'd3
    } pcu_src_e;

endpackage

// File: rtl/pcu_cmp.sv
module pcu_cmp #(
    parameter int XLEN   = 32,
    parameter int LANE_W = 8
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            same
);
    localparam int NLANE = XLEN / LANE_W;

    logic [NLANE-1:0] lane_eq;

    genvar g;
    generate
        for (g = 0; g < NLANE; g++) begin : g_lane
            assign lane_eq[g] = ~|(op_a[g*LANE_W +: LANE_W] ^ op_b[g*LANE_W +: LANE_W]);
        end
    endgenerate

    assign same = &lane_eq;

endmodule

// File: rtl/pcu_target.sv
module pcu_target #(
    parameter int XLEN       = 32,
    parameter int OFF_W      = 16,
    parameter int JT_W       = 26,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    input  logic [JT_W-1:0]  jfield,
    output logic [XLEN-1:0]  seq_addr,
    output logic [XLEN-1:0]  br_addr,
    output logic [XLEN-1:0]  jmp_addr
);
    localparam int SHIFT = $clog2(INSN_BYTES);
    localparam int EXT_W = XLEN - OFF_W - SHIFT;
    localparam int HI_W  = XLEN - JT_W - SHIFT;

    logic [XLEN-1:0] off_bytes;

    assign seq_addr  = pc + XLEN'(INSN_BYTES);
    assign off_bytes = {{EXT_W{off[OFF_W-1]}}, off, {SHIFT{1'b0}}};
    assign br_addr   = seq_addr + off_bytes;
    assign jmp_addr  = {seq_addr[XLEN-1 -: HI_W], jfield, {SHIFT{1'b0}}};

endmodule

// File: rtl/pcu_select.sv
module pcu_select
    import pcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [2:0]      cls,
    input  logic            same,
    input  logic            stall,
    input  logic            rst,
    input  logic [XLEN-1:0] seq_addr,
    input  logic [XLEN-1:0] br_addr,
    input  logic [XLEN-1:0] jmp_addr,
    input  logic [XLEN-1:0] reg_addr,
    output logic [XLEN-1:0] next_addr,
    output logic            link_fire
);
    pcu_class_e cls_e;
    pcu_src_e   src;
    logic       is_link;

    assign cls_e = pcu_class_e'(cls);

    always_comb begin
        src     = SRC_SEQ;
        is_link = 1'b0;
        unique case (cls_e)
            CLS_BEQ: src = same ? SRC_BR : SRC_SEQ;
            CLS_BNE: src = same ? SRC_SEQ : SRC_BR;
            CLS_JMP: src = SRC_JMP;
            CLS_JAL: begin
                src     = SRC_JMP;
                is_link = 1'b1;
            end
            CLS_JRG: src = SRC_REG;
            default: src = SRC_SEQ;
        endcase
    end

    always_comb begin
        unique case (src)
            SRC_BR:  next_addr = br_addr;
            SRC_JMP: next_addr = jmp_addr;
            SRC_REG: next_addr = reg_addr;
            default: next_addr = seq_addr;
        endcase
    end

    assign link_fire = is_link & ~stall & ~rst;

endmodule

// File: rtl/pcu_top.sv
module pcu_top #(
    parameter int XLEN       = 32,
    parameter int OFF_W      = 16,
    parameter int JT_W       = 26,
    parameter int INSN_BYTES = 4,
    parameter int RA_IDX     = 31,
    parameter int LANE_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic [2:0]        ctl_class,
    input  logic [OFF_W-1:0]  br_off,
    input  logic [JT_W-1:0]   jmp_field,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [XLEN-1:0]   jr_addr,
    output logic [XLEN-1:0]   fetch_addr,
    output logic [XLEN-1:0]   link_val,
    output logic [4:0]        link_idx,
    output logic              link_we
);
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] br_addr;
    logic [XLEN-1:0] jmp_addr;
    logic [XLEN-1:0] next_addr;
    logic            same;
    logic            link_fire;

    pcu_cmp #(.XLEN(XLEN), .LANE_W(LANE_W)) u_cmp (
        .op_a (opnd_a),
        .op_b (opnd_b),
        .same (same)
    );

    pcu_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JT_W(JT_W), .INSN_BYTES(INSN_BYTES)) u_tgt (
        .pc       (pc_q),
        .off      (br_off),
        .jfield   (jmp_field),
        .seq_addr (seq_addr),
        .br_addr  (br_addr),
        .jmp_addr (jmp_addr)
    );

    pcu_select #(.XLEN(XLEN)) u_sel (
        .cls       (ctl_class),
        .same      (same),
        .stall     (stall),
        .rst       (rst),
        .seq_addr  (seq_addr),
        .br_addr   (br_addr),
        .jmp_addr  (jmp_addr),
        .reg_addr  (jr_addr),
        .next_addr (next_addr),
        .link_fire (link_fire)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (!stall)
            pc_q <= next_addr;
    end

    assign fetch_addr = pc_q;
    assign link_val   = seq_addr;
    assign link_idx   = 5'(RA_IDX);
    assign link_we    = link_fire;

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> fetch_addr == '0);
    // R1
    reset_nolink_chk: assert property (@(posedge clk) rst |-> !link_we);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(fetch_addr));
    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && ctl_class == 3'd0) |=> fetch_addr == $past(fetch_addr) + XLEN'(INSN_BYTES));
    // R8
    reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && ctl_class == 3'd5) |=> fetch_addr == $past(jr_addr));
    // R10
    link_class_chk: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (ctl_class == 3'd4 && !stall));
    // R7
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_val == fetch_addr + XLEN'(INSN_BYTES) && link_idx == 5'd31));

endmodule

// File: tb/pcu_top_bench.sv
`timescale 1ns/1ps
module pcu_top_bench;
    logic        clk = 1'b0;
    logic        rst, stall;
    logic [2:0]  ctl_class;
    logic [15:0] br_off;
    logic [25:0] jmp_field;
    logic [31:0] opnd_a, opnd_b, jr_addr;
    logic [31:0] fetch_addr, link_val;
    logic [4:0]  link_idx;
    logic        link_we;

    int vectors = 0;
    int misses  = 0;
    logic [31:0] model_pc;

    always #5 clk = ~clk;

    pcu_top u_pcu_top (
        .clk(clk), .rst(rst), .stall(stall), .ctl_class(ctl_class),
        .br_off(br_off), .jmp_field(jmp_field), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .jr_addr(jr_addr), .fetch_addr(fetch_addr),
        .link_val(link_val), .link_idx(link_idx), .link_we(link_we)
    );

    function automatic string tag_of(input logic r, input logic s, input logic [2:0] c);
        if (r) return "R1";
        if (s) return "R9";
        case (c)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [31:0] ref_next(input logic [31:0] pc);
        logic [31:0] nxt;
        logic [31:0] tgt;
        nxt = pc + 32'd4;
        tgt = nxt + {{14{br_off[15]}}, br_off, 2'b00};
        if (rst) return 32'd0;
        if (stall) return pc;
        case (ctl_class)
            3'd1: return (opnd_a == opnd_b) ? tgt : nxt;
            3'd2: return (opnd_a != opnd_b) ? tgt : nxt;
            3'd3, 3'd4: return {nxt[31:28], jmp_field, 2'b00};
            3'd5: return jr_addr;
            default: return nxt;
        endcase
    endfunction

    task automatic check32(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one vector at the falling edge, compare the combinational
    // outputs before the rising edge, then compare the new PC after it.
    task automatic step(input logic r, input logic s, input logic [2:0] c, input logic [15:0] off,
                        input logic [25:0] jf, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] jr);
        string t;
        logic  exp_we;
        @(negedge clk);
        rst = r; stall = s; ctl_class = c; br_off = off; jmp_field = jf;
        opnd_a = a; opnd_b = b; jr_addr = jr;
        #1;
        t = tag_of(r, s, c);
        exp_we = (c == 3'd4) && !s && !r;
        check32(exp_we ? "R7" : "R10", "link_we", {31'd0, link_we}, {31'd0, exp_we});
        if (exp_we) begin
            check32("R7", "link_val", link_val, model_pc + 32'd4);
            check32("R7", "link_idx", {27'd0, link_idx}, 32'd31);
        end
        model_pc = ref_next(model_pc);
        @(posedge clk);
        #1;
        check32(t, "fetch_addr", fetch_addr, model_pc);
    endtask

    initial begin
        #1500000;
        misses++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        model_pc = 32'hDEAD_BEEF;
        // R1: reset with busy inputs, including a JAL to show no link write
        step(1, 0, 3'd4, 16'h0010, 26'h3FFFFFF, 1, 1, 32'h1234);
        step(1, 1, 3'd3, 16'h0010, 26'h0000111, 1, 1, 32'h1234);
        check32("R1", "reset pc", fetch_addr, 32'd0);
        // R2: straight-line and unused codes
        step(0, 0, 3'd0, 0, 0, 0, 0, 0);
        step(0, 0, 3'd6, 0, 0, 0, 0, 0);
        step(0, 0, 3'd7, 0, 0, 0, 0, 0);
        // R3: equal taken, unequal (high byte only) not taken
        step(0, 0, 3'd1, 16'd25, 0, 32'hA5A5_0001, 32'hA5A5_0001, 0);
        step(0, 0, 3'd1, 16'd25, 0, 32'h01A5_0001, 32'hA5A5_0001, 0);
        // R4: differ taken, equal not taken
        step(0, 0, 3'd2, 16'd3, 0, 32'h8000_0000, 32'h0, 0);
        step(0, 0, 3'd2, 16'd3, 0, 32'h7, 32'h7, 0);
        // R5: backward offsets, -1 word lands on PC itself
        step(0, 0, 3'd1, 16'hFFFF, 0, 5, 5, 0);
        check32("R5", "self branch", fetch_addr, model_pc);
        step(0, 0, 3'd2, 16'hFFFC, 0, 5, 6, 0);
        // R6: 2500 -> 10000 from a low PC
        step(0, 0, 3'd3, 0, 26'd2500, 0, 0, 0);
        check32("R6", "jump 2500", fetch_addr, 32'd10000);
        // R8: jump to a high address, then R6 keeps the upper nibble
        step(0, 0, 3'd5, 0, 0, 0, 0, 32'hB000_0040);
        step(0, 0, 3'd3, 0, 26'd2500, 0, 0, 0);
        check32("R6", "upper nibble", fetch_addr, 32'hB000_0000 + 32'd10000);
        // R9/R10: stall around a JAL
        step(0, 1, 3'd4, 0, 26'd77, 0, 0, 0);
        step(0, 0, 3'd4, 0, 26'd77, 0, 0, 0);
        step(0, 1, 3'd5, 0, 0, 0, 0, 32'h44);
        step(0, 0, 3'd4, 0, 26'd12, 0, 0, 0);
        // mixed random run with occasional reset
        for (int i = 0; i < 4000; i++) begin
            logic r, s;
            logic [31:0] a;
            r = ($urandom_range(0, 199) == 0);
            s = ($urandom_range(0, 5) == 0);
            a = $urandom;
            step(r, s, 3'($urandom_range(0, 7)), 16'($urandom), 26'($urandom),
                 a, ($urandom_range(0, 1) == 0) ? a : 32'($urandom), 32'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule